// File: doc/BRIEF.md
# Keyboard Controller Host Register Interface

This block holds the registers that sit between a legacy PC host bus and the embedded CPU of a keyboard controller. The host side has an 8-bit data bus, active-low read and write strobes, and one decoded select line. When the select line is low the host is addressing the data port (0x60). When it is high the host is addressing the command/status port (0x64). Host writes to either port land in one shared input register. A C/D flag records which port was written, and IBF announces that a byte is waiting. Host reads return either the output data register or the status byte.

The CPU side loads the output data register, which raises OBF. It can also raise the keyboard interrupt. The CPU reads the input register and acknowledges it, which clears IBF. It can write the general-purpose status bits, and it can clear OBF and the interrupt explicitly. An auto-clear option lets a host read of the data port clear OBF and the interrupt without CPU help.

Both host strobes pass through a synchronizer. A small state machine accepts one access per strobe pulse. From IDLE it moves to WRITE when the write strobe is seen, or to READ when only the read strobe is seen. WRITE and READ each last one cycle and then go to HOLD. HOLD returns to IDLE once both strobes are released. The register update happens in WRITE. The auto-clear of OBF and the interrupt happens in READ.

Top module: `kbd_host_if`

## Requirements
- R1: A host write pulse with `host_sel_cmd`=0 stores `host_din` in the input register (seen on `cpu_idata`), clears C/D (status bit 3) and sets IBF (status bit 1).
- R2: A host write pulse with `host_sel_cmd`=1 stores `host_din` in the same input register, sets C/D (status bit 3) to 1 and sets IBF.
- R3: `host_dout` shows the output data register when `host_sel_cmd`=0 and the status byte when it is 1. The status byte is laid out as bit 0 OBF, bit 1 IBF, bit 3 C/D. Bits 2 and 7..4 are general flags loaded from `cpu_wdata` by `cpu_flags_we`.
- R4: `cpu_odata_we` loads `cpu_wdata` into the output data register and sets OBF. It drives `kirq` high only if `cfg_irq_en`=1, and `kirq` stays low otherwise.
- R5: With `cfg_auto_clr`=1, a host read pulse of the data port clears OBF and `kirq`. A host read of the command/status port leaves them unchanged.
- R6: With `cfg_auto_clr`=0, a host data-port read leaves OBF and `kirq` unchanged. `cpu_obf_clr` clears both.
- R7: `cpu_idata_re` clears IBF.
- R8: A write strobe held low for many cycles causes exactly one register update. IBF cleared by the CPU while the strobe is still low stays clear.
- R9: If a host write update and `cpu_idata_re` fall in the same clock cycle, IBF ends set.
- R10: After reset, the input and output data registers, the general flags, OBF, IBF and C/D are zero, and `kirq` is low.
- R11: `host_doe` is high exactly while `host_ior_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_iow_n | input | 1 | Host write strobe, active low |
| host_ior_n | input | 1 | Host read strobe, active low |
| host_sel_cmd | input | 1 | 0 selects data port 0x60, 1 selects command/status port 0x64 |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Host data bus drive enable |
| cpu_wdata | input | 8 | CPU write data for output register or flags |
| cpu_odata_we | input | 1 | CPU loads the output data register |
| cpu_flags_we | input | 1 | CPU loads the general status flags |
| cpu_idata_re | input | 1 | CPU acknowledges the input register, clearing IBF |
| cpu_obf_clr | input | 1 | CPU clears OBF and the interrupt |
| cpu_idata | output | 8 | Input register contents |
| cpu_status | output | 8 | Status byte |
| cfg_irq_en | input | 1 | Allows an output data load to raise the interrupt |
| cfg_auto_clr | input | 1 | Lets a host data-port read clear OBF and the interrupt |
| kirq | output | 1 | Keyboard interrupt |

## Verification
The assertions assume that the host never drives both strobes low at once. They also assume that `host_sel_cmd` and `host_din` stay stable for as long as a strobe is low, because the update uses their values in the cycle after synchronization. The bench keeps to these assumptions. Each host access is a single strobe that is held for several cycles with the address and data set beforehand, and the strobe is fully released before the next access begins. CPU-side controls are single-cycle pulses driven between clock edges. One pulse is aligned by cycle count onto the write-update cycle to exercise the collision case.

// File: rtl/kbd_host_pkg.sv
package kbd_host_pkg;

    localparam int DATA_W   = 8;
    localparam int BIT_OBF  = 0;
    localparam int BIT_IBF  = 1;
    localparam int BIT_CD   = 3;
    localparam logic [DATA_W-1:0] GEN_FLAG_MASK = 8'hF4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2,
        ACC_HOLD  = 2'd3
    } acc_state_t;

endpackage

// File: rtl/kbd_strobe_sync.sv
module kbd_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic active
);
    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= ~strobe_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], ~strobe_n};
            end
        end
    endgenerate

    assign active = shreg[STAGES-1];
endmodule

// File: rtl/kbd_host_fsm.sv
module kbd_host_fsm
    import kbd_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic rd_act,
    output logic wr_pulse,
    output logic rd_pulse
);
    acc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (wr_act)      state_d = ACC_WRITE;
                else if (rd_act) state_d = ACC_READ;
            end
            ACC_WRITE: state_d = ACC_HOLD;
            ACC_READ:  state_d = ACC_HOLD;
            ACC_HOLD: begin
                if (!wr_act && !rd_act) state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_pulse = 1'b0;
        rd_pulse = 1'b0;
        unique case (state_q)
            ACC_WRITE: wr_pulse = 1'b1;
            ACC_READ:  rd_pulse = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/kbd_host_regs.sv
module kbd_host_regs
    import kbd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic              rd_pulse,
    input  logic              host_sel_cmd,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_odata_we,
    input  logic              cpu_flags_we,
    input  logic              cpu_idata_re,
    input  logic              cpu_obf_clr,
    input  logic              cfg_irq_en,
    input  logic              cfg_auto_clr,
    output logic [DATA_W-1:0] idata,
    output logic [DATA_W-1:0] odata,
    output logic [DATA_W-1:0] status,
    output logic              kirq
);
    logic              ibf_q, obf_q, cd_q, kirq_q;
    logic [DATA_W-1:0] gflags_q;
    logic              auto_clear;

    assign auto_clear = rd_pulse && !host_sel_cmd && cfg_auto_clr;

    // input side: host write has priority over the CPU acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idata <= '0;
            ibf_q <= 1'b0;
            cd_q  <= 1'b0;
        end else if (wr_pulse) begin
            idata <= host_din;
            ibf_q <= 1'b1;
            cd_q  <= host_sel_cmd;
        end else if (cpu_idata_re) begin
            ibf_q <= 1'b0;
        end
    end

    // output side: CPU load has priority over any clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odata  <= '0;
            obf_q  <= 1'b0;
            kirq_q <= 1'b0;
        end else if (cpu_odata_we) begin
            odata  <= cpu_wdata;
            obf_q  <= 1'b1;
            kirq_q <= cfg_irq_en;
        end else if (cpu_obf_clr || auto_clear) begin
            obf_q  <= 1'b0;
            kirq_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            gflags_q <= '0;
        else if (cpu_flags_we) gflags_q <= cpu_wdata & GEN_FLAG_MASK;
    end

    always_comb begin
        status          = gflags_q;
        status[BIT_OBF] = obf_q;
        status[BIT_IBF] = ibf_q;
        status[BIT_CD]  = cd_q;
    end

    assign kirq = kirq_q;
endmodule

// File: rtl/kbd_host_if.sv
module kbd_host_if
    import kbd_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_iow_n,
    input  logic              host_ior_n,
    input  logic              host_sel_cmd,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_doe,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_odata_we,
    input  logic              cpu_flags_we,
    input  logic              cpu_idata_re,
    input  logic              cpu_obf_clr,
    output logic [DATA_W-1:0] cpu_idata,
    output logic [DATA_W-1:0] cpu_status,
    input  logic              cfg_irq_en,
    input  logic              cfg_auto_clr,
    output logic              kirq
);
    logic              wr_act, rd_act;
    logic              wr_pulse, rd_pulse;
    logic [DATA_W-1:0] odata, status;

    kbd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_iow_n), .active(wr_act)
    );
    kbd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
        .clk(clk), .rst_n(rst_n), .strobe_n(host_ior_n), .active(rd_act)
    );

    kbd_host_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .rd_act(rd_act),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse)
    );

    kbd_host_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .host_sel_cmd(host_sel_cmd), .host_din(host_din),
        .cpu_wdata(cpu_wdata), .cpu_odata_we(cpu_odata_we),
        .cpu_flags_we(cpu_flags_we), .cpu_idata_re(cpu_idata_re),
        .cpu_obf_clr(cpu_obf_clr),
        .cfg_irq_en(cfg_irq_en), .cfg_auto_clr(cfg_auto_clr),
        .idata(cpu_idata), .odata(odata), .status(status), .kirq(kirq)
    );

    assign host_dout  = host_sel_cmd ? status : odata;
    assign host_doe   = ~host_ior_n;
    assign cpu_status = status;
endmodule

// File: rtl/kbd_host_chk.sv
module kbd_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_pulse,
    input logic       rd_pulse,
    input logic       host_sel_cmd,
    input logic [7:0] host_din,
    input logic       cpu_odata_we,
    input logic       cpu_idata_re,
    input logic       cpu_obf_clr,
    input logic       cfg_irq_en,
    input logic       cfg_auto_clr,
    input logic [7:0] cpu_idata,
    input logic [7:0] cpu_status,
    input logic       kirq
);
    AST_DATA_WR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !host_sel_cmd) |=> (cpu_status[1] && !cpu_status[3] && cpu_idata == $past(host_din))); // R1
    AST_CMD_WR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && host_sel_cmd) |=> (cpu_status[1] && cpu_status[3] && cpu_idata == $past(host_din))); // R2
    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_odata_we |=> (cpu_status[0] && kirq == $past(cfg_irq_en))); // R4
    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !host_sel_cmd && cfg_auto_clr && !cpu_odata_we) |=> (!cpu_status[0] && !kirq)); // R5
    AST_OBF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_odata_we && !cpu_obf_clr && !(rd_pulse && !host_sel_cmd && cfg_auto_clr))
            |=> (cpu_status[0] == $past(cpu_status[0]) && kirq == $past(kirq))); // R6
    AST_EXPLICIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_obf_clr && !cpu_odata_we) |=> (!cpu_status[0] && !kirq)); // R6
    AST_ACK_CLEARS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_idata_re && !wr_pulse) |=> !cpu_status[1]); // R7
    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse || rd_pulse) |=> (!wr_pulse && !rd_pulse)); // R8
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pulse, rd_pulse})); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && cpu_idata_re) |=> cpu_status[1]); // R9
endmodule

bind kbd_host_if kbd_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
    .host_sel_cmd(host_sel_cmd), .host_din(host_din),
    .cpu_odata_we(cpu_odata_we), .cpu_idata_re(cpu_idata_re),
    .cpu_obf_clr(cpu_obf_clr), .cfg_irq_en(cfg_irq_en),
    .cfg_auto_clr(cfg_auto_clr), .cpu_idata(cpu_idata),
    .cpu_status(cpu_status), .kirq(kirq)
);

// File: tb/kbd_host_if_tb_top.sv
`timescale 1ns/1ps
module kbd_host_if_tb_top;

    localparam int K_STATUS = 0;
    localparam int K_HDOUT  = 1;
    localparam int K_IDATA  = 2;
    localparam int K_KIRQ   = 3;
    localparam int K_DOE    = 4;

    typedef struct {
        string      req;
        int         kind;
        logic [7:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_iow_n = 1'b1, host_ior_n = 1'b1, host_sel_cmd = 1'b0;
    logic [7:0] host_din = '0, cpu_wdata = '0;
    logic       cpu_odata_we = 0, cpu_flags_we = 0, cpu_idata_re = 0, cpu_obf_clr = 0;
    logic       cfg_irq_en = 0, cfg_auto_clr = 0;
    logic [7:0] host_dout, cpu_idata, cpu_status;
    logic       host_doe, kirq;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;

    always #4 clk = ~clk;

    kbd_host_if dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_iow_n(host_iow_n), .host_ior_n(host_ior_n),
        .host_sel_cmd(host_sel_cmd), .host_din(host_din),
        .host_dout(host_dout), .host_doe(host_doe),
        .cpu_wdata(cpu_wdata), .cpu_odata_we(cpu_odata_we),
        .cpu_flags_we(cpu_flags_we), .cpu_idata_re(cpu_idata_re),
        .cpu_obf_clr(cpu_obf_clr), .cpu_idata(cpu_idata),
        .cpu_status(cpu_status), .cfg_irq_en(cfg_irq_en),
        .cfg_auto_clr(cfg_auto_clr), .kirq(kirq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                case (it.kind)
                    K_STATUS: act = cpu_status;
                    K_HDOUT:  act = host_dout;
                    K_IDATA:  act = cpu_idata;
                    K_KIRQ:   act = {7'b0, kirq};
                    default:  act = {7'b0, host_doe};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input string req, input int kind, input logic [7:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        exp_q.push_back(it);
        wait (exp_q.size() == 0);
    endtask

    task automatic host_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        host_sel_cmd = sel; host_din = d; host_iow_n = 1'b0;
        repeat (6) @(negedge clk);
        host_iow_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(input logic sel, input string req, input logic [7:0] exp_dout);
        @(negedge clk);
        host_sel_cmd = sel; host_ior_n = 1'b0;
        repeat (5) @(negedge clk);
        expect_item(req, K_HDOUT, exp_dout);
        expect_item("R11", K_DOE, 8'h01);
        host_ior_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cpu_pulse(input int which, input logic [7:0] d);
        @(negedge clk);
        cpu_wdata = d;
        case (which)
            0: cpu_odata_we = 1'b1;
            1: cpu_flags_we = 1'b1;
            2: cpu_idata_re = 1'b1;
            default: cpu_obf_clr = 1'b1;
        endcase
        @(negedge clk);
        cpu_odata_we = 0; cpu_flags_we = 0; cpu_idata_re = 0; cpu_obf_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 reset state
        expect_item("R10", K_STATUS, 8'h00);
        expect_item("R10", K_KIRQ,   8'h00);
        expect_item("R10", K_IDATA,  8'h00);
        expect_item("R10", K_HDOUT,  8'h00);
        expect_item("R11", K_DOE,    8'h00);

        // R1 data port write
        host_write(1'b0, 8'hA5);
        expect_item("R1", K_IDATA,  8'hA5);
        expect_item("R1", K_STATUS, 8'h02);
        // R7 acknowledge
        cpu_pulse(2, 8'h00);
        expect_item("R7", K_STATUS, 8'h00);

        // R2 command port write
        host_write(1'b1, 8'h3C);
        expect_item("R2", K_IDATA,  8'h3C);
        expect_item("R2", K_STATUS, 8'h0A);
        cpu_pulse(2, 8'h00);
        expect_item("R7", K_STATUS, 8'h08);

        // R8 long strobe, ack while still held
        @(negedge clk);
        host_sel_cmd = 1'b0; host_din = 8'h11; host_iow_n = 1'b0;
        repeat (6) @(negedge clk);
        expect_item("R8", K_STATUS, 8'h02);
        cpu_idata_re = 1'b1;
        @(negedge clk);
        cpu_idata_re = 1'b0;
        repeat (8) @(negedge clk);
        expect_item("R8", K_STATUS, 8'h00);
        host_iow_n = 1'b1;
        repeat (5) @(negedge clk);
        expect_item("R8", K_STATUS, 8'h00);
        expect_item("R8", K_IDATA,  8'h11);

        // R9 ack lands on the update cycle (two sync stages + one state cycle)
        @(negedge clk);
        host_sel_cmd = 1'b1; host_din = 8'h5E; host_iow_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cpu_idata_re = 1'b1;
        @(negedge clk);
        cpu_idata_re = 1'b0;
        expect_item("R9", K_STATUS, 8'h0A);
        host_iow_n = 1'b1;
        repeat (4) @(negedge clk);
        cpu_pulse(2, 8'h00);
        expect_item("R7", K_STATUS, 8'h08);
        host_write(1'b0, 8'h00);
        cpu_pulse(2, 8'h00);
        expect_item("R7", K_STATUS, 8'h00);

        // R4/R5 interrupt enabled, auto clear on
        cfg_irq_en = 1'b1; cfg_auto_clr = 1'b1;
        cpu_pulse(0, 8'h5A);
        expect_item("R4", K_STATUS, 8'h01);
        expect_item("R4", K_KIRQ,   8'h01);
        host_read(1'b1, "R3", 8'h01);
        expect_item("R5", K_STATUS, 8'h01);
        expect_item("R5", K_KIRQ,   8'h01);
        host_read(1'b0, "R3", 8'h5A);
        expect_item("R5", K_STATUS, 8'h00);
        expect_item("R5", K_KIRQ,   8'h00);

        // R4 interrupt disabled
        cfg_irq_en = 1'b0; cfg_auto_clr = 1'b0;
        cpu_pulse(0, 8'h77);
        expect_item("R4", K_STATUS, 8'h01);
        expect_item("R4", K_KIRQ,   8'h00);
        // R6 no auto clear
        host_read(1'b0, "R3", 8'h77);
        expect_item("R6", K_STATUS, 8'h01);
        cpu_pulse(3, 8'h00);
        expect_item("R6", K_STATUS, 8'h00);

        cfg_irq_en = 1'b1;
        cpu_pulse(0, 8'h42);
        expect_item("R4", K_KIRQ, 8'h01);
        host_read(1'b0, "R3", 8'h42);
        expect_item("R6", K_KIRQ,   8'h01);
        expect_item("R6", K_STATUS, 8'h01);
        cpu_pulse(3, 8'h00);
        expect_item("R6", K_KIRQ,   8'h00);
        expect_item("R6", K_STATUS, 8'h00);

        // R3 general flags
        cpu_pulse(1, 8'hFF);
        expect_item("R3", K_STATUS, 8'hF4);
        host_read(1'b1, "R3", 8'hF4);
        host_write(1'b1, 8'hC3);
        expect_item("R3", K_STATUS, 8'hFE);
        cpu_pulse(1, 8'h00);
        expect_item("R3", K_STATUS, 8'h0A);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule